// File: doc/BRIEF.md
# Transceiver Low-Power State Controller

This block decides which low-power state a 10/100 Ethernet transceiver is in and drives the enables that follow from that decision. The enables cover the analog front end, the PLL, the crystal oscillator, the digital datapath, the MAC-side outputs and the management port. Four requests can arrive at once. Three of them are register bits: analog-off, link-down power saving and power-down. The fourth is a hardware isolation pin. The link-down power-saving request can also come from a strap pin. The controller settles the requests by fixed priority. Isolation is the highest, then power-down, then analog-off, then link-down power saving.

In link-down power saving the transmitter is never switched off. While the link is down, a sequencer replaces the normal link pulses or idle stream with a sparse probe pattern. When the receiver reports energy on the line, the probe stops and normal signalling resumes for a wake window. If the link comes up in that window, the sequencer leaves the probe state. If it does not, probing starts again.

The link and energy indications are asynchronous and pass through a two-flop synchronizer. The request inputs are register bits and strap levels that are already in the block's clock domain. They are registered once into the current mode.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: After reset, the current mode is normal (`mode_o` = 0), every enable output is 1 and `tx_probe_o` is 0.
- R2: One clock edge after `iso_pin_i` is seen high, `mode_o` is 4 and every enable output is 0, including `mgmt_en_o` and `mac_if_en_o`. This holds whatever the other requests are.
- R3: With power-down requested and no isolation, `mode_o` is 3 one edge later. Only `mgmt_en_o` stays 1, and the analog, PLL, crystal, digital and MAC-side enables are 0.
- R4: With analog-off requested and neither power-down nor isolation, `mode_o` is 2 one edge later. `afe_en_o` and `pll_en_o` are 0, and `xtal_en_o`, `dig_en_o`, `mac_if_en_o` and `mgmt_en_o` are 1.
- R5: Link-down power saving is requested by `reg_ldps_i` or by `ldps_pin_i`. When it is the only request, `mode_o` is 1 one edge later and every enable stays 1.
- R6: When several requests are active, the mode follows the priority order isolation (4) > power-down (3) > analog-off (2) > link-down saving (1) > normal (0).
- R7: In mode 1, with the synchronized link down, the sequencer enters the probe state on the next edge, and `tx_probe_o` (1 = probe pattern, 0 = normal signalling) is 1.
- R8: While probing, synchronized energy stops the probe on the next edge. That is the third rising edge after `energy_i` rises. Normal signalling then holds for WAKE_CYCLES clocks.
- R9: If the synchronized link is up at the end of the wake window or during probing, the sequencer returns to non-probe. If the window ends with the link still down, probing restarts.
- R10: When every request except link-down saving clears, all enables are 1 one edge later.
- R11: `tx_probe_o` is 0 whenever `mode_o` is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_aoff_i | input | 1 | Analog-off request bit |
| reg_ldps_i | input | 1 | Link-down power-saving request bit |
| reg_pdn_i | input | 1 | Power-down request bit |
| ldps_pin_i | input | 1 | Link-down power-saving strap pin |
| iso_pin_i | input | 1 | Isolation pin |
| link_up_i | input | 1 | Asynchronous link-status indication |
| energy_i | input | 1 | Asynchronous receive-energy indication |
| mode_o | output | 3 | Current mode: 0 normal, 1 link-down saving, 2 analog-off, 3 power-down, 4 isolation |
| afe_en_o | output | 1 | Analog transmit/receive enable |
| pll_en_o | output | 1 | PLL enable |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| dig_en_o | output | 1 | Digital datapath enable |
| mac_if_en_o | output | 1 | MAC-side output enable |
| mgmt_en_o | output | 1 | Management port enable |
| tx_probe_o | output | 1 | 1 selects the probe pattern, 0 normal signalling |

## Verification
The assertions assume that the request inputs are synchronous to `clk` and stay stable across the sampling edge. They also assume that the only timing relation between `energy_i` or `link_up_i` and the mode is the one the synchronizer fixes. The bench keeps to these assumptions by changing every input one time unit after a rising edge. It also holds each link and energy level for at least one cycle, so the two-flop delay in its model is exact. The stimulus first walks the priority ladder down from all requests active. It then runs the probe, wake, timeout and link-up paths in link-down saving, reached through both the strap pin and the register bit. Last, it overrides the mode while probing is in progress.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    typedef enum logic [2:0] {
        MODE_NORMAL = 3'd0,
        MODE_LDPS   = 3'd1,
        MODE_AOFF   = 3'd2,
        MODE_PDN    = 3'd3,
        MODE_ISO    = 3'd4
    } pwr_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_PROBE = 2'd1,
        SEQ_WAKE  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic afe;
        logic pll;
        logic xtal;
        logic dig;
        logic mac;
        logic mgmt;
    } pwr_en_t;

    typedef struct packed {
        logic iso;
        logic pdn;
        logic aoff;
        logic ldps;
    } pwr_req_t;

    function automatic pwr_mode_e mode_pick(input pwr_req_t r);
        if (r.iso)       return MODE_ISO;
        else if (r.pdn)  return MODE_PDN;
        else if (r.aoff) return MODE_AOFF;
        else if (r.ldps) return MODE_LDPS;
        else             return MODE_NORMAL;
    endfunction

    function automatic pwr_en_t en_decode(input pwr_mode_e m);
        pwr_en_t e;
        e = '{afe: 1'b1, pll: 1'b1, xtal: 1'b1, dig: 1'b1, mac: 1'b1, mgmt: 1'b1};
        case (m)
            MODE_AOFF: begin
                e.afe = 1'b0;
                e.pll = 1'b0;
            end
            MODE_PDN: begin
                e.afe  = 1'b0;
                e.pll  = 1'b0;
                e.xtal = 1'b0;
                e.dig  = 1'b0;
                e.mac  = 1'b0;
            end
            MODE_ISO: e = '0;
            default: ;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pwr_arb.sv
module pwr_arb
    import pwr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  pwr_req_t  req_i,
    output pwr_mode_e mode_o
);
    pwr_mode_e mode_q;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_NORMAL;
        else     mode_q <= mode_pick(req_i);
    end

    assign mode_o = mode_q;
endmodule

// File: rtl/pwr_ldps_seq.sv
module pwr_ldps_seq
    import pwr_pkg::*;
#(
    parameter int WAKE_CYCLES = 1024
) (
    input  logic      clk,
    input  logic      rst,
    input  pwr_mode_e mode_i,
    input  logic      link_s_i,
    input  logic      energy_s_i,
    output logic      probe_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] WAKE_LAST = CW'(WAKE_CYCLES - 1);

    seq_state_e st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (mode_i != MODE_LDPS) begin
            st_d  = SEQ_IDLE;
            cnt_d = '0;
        end else begin
            case (st_q)
                SEQ_IDLE: if (!link_s_i) st_d = SEQ_PROBE;
                SEQ_PROBE: begin
                    if (link_s_i) st_d = SEQ_IDLE;
                    else if (energy_s_i) begin
                        st_d  = SEQ_WAKE;
                        cnt_d = '0;
                    end
                end
                SEQ_WAKE: begin
                    if (link_s_i) st_d = SEQ_IDLE;
                    else if (cnt_q == WAKE_LAST) begin
                        st_d  = SEQ_PROBE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= SEQ_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign probe_o = (st_q == SEQ_PROBE) && (mode_i == MODE_LDPS);
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
    import pwr_pkg::*;
#(
    parameter int WAKE_CYCLES = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_aoff_i,
    input  logic       reg_ldps_i,
    input  logic       reg_pdn_i,
    input  logic       ldps_pin_i,
    input  logic       iso_pin_i,
    input  logic       link_up_i,
    input  logic       energy_i,
    output logic [2:0] mode_o,
    output logic       afe_en_o,
    output logic       pll_en_o,
    output logic       xtal_en_o,
    output logic       dig_en_o,
    output logic       mac_if_en_o,
    output logic       mgmt_en_o,
    output logic       tx_probe_o
);
    pwr_req_t  req;
    pwr_mode_e mode;
    pwr_en_t   en;
    logic [1:0] async_in, async_s;
    logic       link_s, energy_s;

    assign req = '{iso: iso_pin_i, pdn: reg_pdn_i, aoff: reg_aoff_i,
                   ldps: reg_ldps_i | ldps_pin_i};
    assign async_in = {link_up_i, energy_i};

    pwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d_i(async_in), .q_o(async_s)
    );
    assign link_s   = async_s[1];
    assign energy_s = async_s[0];

    pwr_arb u_arb (.clk(clk), .rst(rst), .req_i(req), .mode_o(mode));

    pwr_ldps_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .mode_i(mode), .link_s_i(link_s),
        .energy_s_i(energy_s), .probe_o(tx_probe_o)
    );

    assign en          = en_decode(mode);
    assign mode_o      = mode;
    assign afe_en_o    = en.afe;
    assign pll_en_o    = en.pll;
    assign xtal_en_o   = en.xtal;
    assign dig_en_o    = en.dig;
    assign mac_if_en_o = en.mac;
    assign mgmt_en_o   = en.mgmt;
endmodule

// File: rtl/phy_pwr_ctrl_chk.sv
module phy_pwr_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_aoff_i,
    input logic       reg_ldps_i,
    input logic       reg_pdn_i,
    input logic       ldps_pin_i,
    input logic       iso_pin_i,
    input logic [2:0] mode_o,
    input logic       afe_en_o,
    input logic       pll_en_o,
    input logic       xtal_en_o,
    input logic       dig_en_o,
    input logic       mac_if_en_o,
    input logic       mgmt_en_o,
    input logic       tx_probe_o,
    input logic       energy_s
);
    a_r2_iso_all_off: assert property (@(posedge clk) disable iff (rst)
        iso_pin_i |=> (mode_o == 3'd4 && !mgmt_en_o && !mac_if_en_o && !afe_en_o && !dig_en_o));

    a_r3_pdn_mgmt_only: assert property (@(posedge clk) disable iff (rst)
        (reg_pdn_i && !iso_pin_i) |=> (mgmt_en_o && !dig_en_o && !afe_en_o && !xtal_en_o));

    a_r4_aoff_digital_alive: assert property (@(posedge clk) disable iff (rst)
        (reg_aoff_i && !reg_pdn_i && !iso_pin_i) |=>
        (!afe_en_o && !pll_en_o && xtal_en_o && dig_en_o && mgmt_en_o));

    a_r5_ldps_enables_on: assert property (@(posedge clk) disable iff (rst)
        ((reg_ldps_i || ldps_pin_i) && !reg_aoff_i && !reg_pdn_i && !iso_pin_i) |=>
        (mode_o == 3'd1 && afe_en_o && pll_en_o));

    a_r8_energy_stops_probe: assert property (@(posedge clk) disable iff (rst)
        (tx_probe_o && energy_s) |=> !tx_probe_o);

    a_r10_release_restores: assert property (@(posedge clk) disable iff (rst)
        (!iso_pin_i && !reg_pdn_i && !reg_aoff_i) |=>
        (afe_en_o && pll_en_o && xtal_en_o && dig_en_o && mac_if_en_o && mgmt_en_o));

    a_r11_no_probe_when_isolated: assert property (@(posedge clk) disable iff (rst)
        iso_pin_i |=> !tx_probe_o);
endmodule

bind phy_pwr_ctrl phy_pwr_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .reg_aoff_i(reg_aoff_i), .reg_ldps_i(reg_ldps_i),
    .reg_pdn_i(reg_pdn_i), .ldps_pin_i(ldps_pin_i), .iso_pin_i(iso_pin_i),
    .mode_o(mode_o), .afe_en_o(afe_en_o), .pll_en_o(pll_en_o),
    .xtal_en_o(xtal_en_o), .dig_en_o(dig_en_o), .mac_if_en_o(mac_if_en_o),
    .mgmt_en_o(mgmt_en_o), .tx_probe_o(tx_probe_o), .energy_s(energy_s)
);

// File: tb/sim_phy_pwr_ctrl.sv
module sim_phy_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_aoff = 0, reg_ldps = 0, reg_pdn = 0, ldps_pin = 0, iso_pin = 0;
    logic link_up = 0, energy = 0;
    logic [2:0] mode;
    logic afe, pll, xtal, dig, mac, mgmt, probe;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_pwr_ctrl #(.WAKE_CYCLES(WAKE)) u0 (
        .clk(clk), .rst(rst), .reg_aoff_i(reg_aoff), .reg_ldps_i(reg_ldps),
        .reg_pdn_i(reg_pdn), .ldps_pin_i(ldps_pin), .iso_pin_i(iso_pin),
        .link_up_i(link_up), .energy_i(energy), .mode_o(mode),
        .afe_en_o(afe), .pll_en_o(pll), .xtal_en_o(xtal), .dig_en_o(dig),
        .mac_if_en_o(mac), .mgmt_en_o(mgmt), .tx_probe_o(probe)
    );

    // behavioural reference
    int m_mode, m_prev, m_st, m_cnt;
    bit m_first;
    logic [1:0] le_q[$];   // {link, energy} history through the synchronizer

    function automatic int want_mode();
        if (iso_pin) return 4;
        if (reg_pdn) return 3;
        if (reg_aoff) return 2;
        if (reg_ldps || ldps_pin) return 1;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_prev = 0; m_st = 0; m_cnt = 0; m_first = 1;
            le_q = '{2'b00, 2'b00};
        end else begin
            logic ls, es;
            ls = le_q[0][1];
            es = le_q[0][0];
            if (m_mode != 1) begin
                m_st = 0; m_cnt = 0;
            end else if (m_st == 0) begin
                if (!ls) m_st = 1;
            end else if (m_st == 1) begin
                if (ls) m_st = 0;
                else if (es) begin m_st = 2; m_cnt = 0; end
            end else begin
                if (ls) m_st = 0;
                else if (m_cnt == WAKE - 1) begin m_st = 1; m_cnt = 0; end
                else m_cnt++;
            end
            m_prev = m_mode;
            m_mode = want_mode();
            void'(le_q.pop_front());
            le_q.push_back({link_up, energy});
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [5:0] e_exp;
            string re, rp;
            case (m_mode)
                2: begin e_exp = 6'b001111; re = "R4"; end
                3: begin e_exp = 6'b000001; re = "R3"; end
                4: begin e_exp = 6'b000000; re = "R2"; end
                1: begin e_exp = 6'b111111; re = "R5"; end
                default: begin e_exp = 6'b111111; re = "R10"; end
            endcase
            if (m_first) re = "R1";
            else if (m_mode <= 1 && m_prev >= 2) re = "R10";
            if (m_mode != 1) rp = "R11";
            else if (m_st == 1) rp = "R7";
            else if (m_st == 2) rp = "R8";
            else rp = "R9";
            chk(m_first ? "R1" : "R6", "mode", int'(mode), m_mode);
            chk(re, "enables", int'({afe, pll, xtal, dig, mac, mgmt}), int'(e_exp));
            chk(m_first ? "R1" : rp, "tx_probe", int'(probe), (m_st == 1 && m_mode == 1) ? 1 : 0);
            m_first = 0;
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        fork
            begin
                tick(4);
                rst = 0;
                tick(4);
                reg_aoff = 1; tick(5); reg_aoff = 0; tick(3);
                reg_pdn = 1;  tick(5); reg_pdn = 0;  tick(3);
                iso_pin = 1;  tick(5); iso_pin = 0;  tick(3);
                // priority ladder
                iso_pin = 1; reg_pdn = 1; reg_aoff = 1; reg_ldps = 1; tick(4);
                iso_pin = 0;  tick(4);
                reg_pdn = 0;  tick(4);
                reg_aoff = 0; tick(4);
                reg_ldps = 0; tick(4);
                // LDPS by strap pin, link down
                ldps_pin = 1; tick(10);
                energy = 1; tick(5); energy = 0;
                tick(WAKE + 8);
                energy = 1; tick(4); energy = 0;
                link_up = 1; tick(8);
                link_up = 0; tick(8);
                ldps_pin = 0; tick(4);
                // LDPS by register bit, then override while probing
                reg_ldps = 1; tick(8);
                reg_aoff = 1; tick(3);
                reg_aoff = 0; tick(5);
                iso_pin = 1; tick(3);
                iso_pin = 0; tick(5);
                energy = 1; tick(3); link_up = 1; tick(4);
                energy = 0; link_up = 0; reg_ldps = 0; tick(6);
                done = 1;
            end
            begin
                repeat (100000) @(posedge clk);
                if (!done) begin
                    n_vec++; n_bad++;
                    $display("FAIL watchdog expired");
                    done = 1;
                end
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule